// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is an SPI master that moves one burst of 8-bit words through a shared byte buffer. The host fills the buffer, sets up a small control register (clock divider, phase, polarity, bit order), then pulses `start` with a byte count and a one-hot chip-select mask. The engine drives the chosen select line low and, for each byte in turn, reads it from buffer index k and shifts it out on MOSI. It shifts the reply in from MISO and writes the received byte back into index k, over the byte it sent. After the last byte it releases the select line and pulses `done`. When the burst ends, the buffer holds the received stream starting at index 0. Receive-only data is sent as whatever the host placed in the buffer, normally zeros.

The controller is a single state machine with the states IDLE, FETCH, LOAD, SHIFT, STORE and DONE. The transitions are:
- IDLE→FETCH on a start with a nonzero count.
- IDLE→DONE on a start with a zero count.
- FETCH→LOAD always.
- LOAD→SHIFT always.
- SHIFT→STORE after the sixteenth SCLK edge.
- STORE→FETCH when more bytes remain.
- STORE→DONE after the last byte.
- DONE→IDLE always.

The buffer port has a read latency of one cycle. The address is presented in FETCH and the data is captured in LOAD.

Top module: `spi_burst_engine`

## Requirements
- R1: The control register keeps bits [1:0] as the divider code, bit 2 as CPHA, bit 3 as CPOL and bit 5 as LSB-first. Bits 4, 6 and 7 always read back as zero, whatever value is written.
- R2: While a byte is shifting, each SCLK half period lasts 2, 8, 32 or 64 reference clocks for divider codes 00, 01, 10 and 11. This gives SCLK at the reference clock divided by 4, 16, 64 or 128.
- R3: SCLK rests at the CPOL level whenever no edge is being produced.
  - With CPHA=0, MOSI is valid before the first edge of a byte and MISO is sampled on leading edges.
  - With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R4: With bit 5 clear, each byte is sent and received most significant bit first. With bit 5 set, it is sent and received least significant bit first.
- R5: The byte read from buffer index k is the k-th byte sent. The 8-bit word received during that byte is written back to index k.
- R6: A count larger than 200 is treated as 200. No buffer write goes to an index of 200 or more.
- R7: During a burst, `ss_n` equals the inverted mask taken at start and does not change until the burst ends. Outside a burst, every `ss_n` line is high.
- R8: `busy` is high from the cycle after an accepted start until chip select is released. `done` is high for exactly one cycle, the cycle in which chip select is released, and `busy` is low in that cycle.
- R9: A start pulse that arrives while `busy` is high is ignored. It does not change the current burst and does not queue a new one.
- R10: A start with count zero raises `done` in the next cycle. It never asserts chip select or `busy` and writes nothing to the buffer.
- R11: Control register writes while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write value |
| cfg_q | output | 8 | Control register contents |
| start | input | 1 | Burst start pulse |
| byte_cnt | input | 8 | Number of bytes in the burst |
| ss_mask | input | 4 | One-hot chip-select mask, bit i selects line i |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| buf_addr | output | 8 | Buffer index for read and write |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after the address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Received byte to store |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Master data in |
| ss_n | output | 4 | Active-low chip selects |

## Verification
A wrong edge counter or wrong phase selection shows up within one byte. The bit pattern a modelled slave receives, or the byte written back to the buffer, comes out rotated or mirrored, and the half-period spacing on SCLK differs from the divider code. A byte index that runs ahead or stops early shows up at the end of the burst as a wrong number of buffer writes or a changed byte beyond the count. A controller that leaves its idle state wrongly shows up within a cycle as a moving `ss_n`, a late or doubled `done`, or a `busy` level that disagrees with chip select.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SHIFT,
        ST_STORE,
        ST_DONE
    } burst_state_t;

    localparam int CTL_CPHA = 2;
    localparam int CTL_CPOL = 3;
    localparam int CTL_LSB  = 5;
    localparam logic [7:0] CTL_KEEP = 8'b0010_1111;

    localparam int HALF_MAX = 64;
    localparam int HALF_W   = $clog2(HALF_MAX + 1);

    // Reference clocks per SCLK half period for each divider code
    function automatic logic [HALF_W-1:0] half_len(input logic [1:0] code);
        logic [HALF_W-1:0] h;
        unique case (code)
            2'b00:   h = HALF_W'(2);
            2'b01:   h = HALF_W'(8);
            2'b10:   h = HALF_W'(32);
            default: h = HALF_W'(64);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = run && (cnt == half - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] load_word,
    input  logic          lsb_first,
    input  logic          shift_en,
    input  logic          sample_en,
    input  logic          miso,
    output logic          mosi,
    output logic [WW-1:0] rx_word
);
    logic [WW-1:0] tx_sr;
    logic [WW-1:0] rx_sr;

    assign mosi    = lsb_first ? tx_sr[0] : tx_sr[WW-1];
    assign rx_word = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_word;
            rx_sr <= '0;
        end else begin
            if (shift_en)
                tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
            if (sample_en)
                rx_sr <= lsb_first ? {miso, rx_sr[WW-1:1]} : {rx_sr[WW-2:0], miso};
        end
    end

    a_r3_edge_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && sample_en));

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int MAX_BYTES = 200,
    parameter int NUM_SS    = 4,
    parameter int AW        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_q,
    input  logic              start,
    input  logic [AW-1:0]     byte_cnt,
    input  logic [NUM_SS-1:0] ss_mask,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    localparam logic [AW-1:0] MAX_B    = AW'(MAX_BYTES);
    localparam int            EDGES    = 16;
    localparam int            EW       = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDG = EW'(EDGES - 1);

    burst_state_t      state, nxt;
    logic [AW-1:0]     idx, last_q, cnt_eff;
    logic [NUM_SS-1:0] mask_q;
    logic [EW-1:0]     edge_q;
    logic              sclk_q, tick, cpha, shift_en, sample_en;
    logic [7:0]        rx_word;

    assign cpha    = cfg_q[CTL_CPHA];
    assign cnt_eff = (byte_cnt > MAX_B) ? MAX_B : byte_cnt;

    spi_half_timer #(.CW(HALF_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_SHIFT),
        .half  (half_len(cfg_q[1:0])),
        .tick  (tick)
    );

    assign sample_en = tick && (edge_q[0] == cpha);
    assign shift_en  = tick && (edge_q[0] != cpha) && (edge_q != '0);

    spi_shift_unit #(.WW(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == ST_LOAD),
        .load_word (buf_rdata),
        .lsb_first (cfg_q[CTL_LSB]),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = (byte_cnt == '0) ? ST_DONE : ST_FETCH;
            ST_FETCH: nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_SHIFT;
            ST_SHIFT: if (tick && edge_q == LAST_EDG) nxt = ST_STORE;
            ST_STORE: nxt = (idx == last_q) ? ST_DONE : ST_FETCH;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Burst datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            last_q <= '0;
            mask_q <= '0;
            edge_q <= '0;
            sclk_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk_q <= cfg_q[CTL_CPOL];
                    if (cfg_we) cfg_q <= cfg_wdata & CTL_KEEP;
                    if (start) begin
                        idx    <= '0;
                        mask_q <= ss_mask;
                        last_q <= cnt_eff - AW'(1);
                    end
                end
                ST_LOAD:  edge_q <= '0;
                ST_SHIFT: if (tick) begin
                    sclk_q <= ~sclk_q;
                    edge_q <= edge_q + EW'(1);
                end
                ST_STORE: idx <= idx + AW'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == ST_FETCH) || (state == ST_LOAD) ||
                    (state == ST_SHIFT) || (state == ST_STORE);
        done      = (state == ST_DONE);
        ss_n      = busy ? ~mask_q : '1;
        buf_addr  = idx;
        buf_we    = (state == ST_STORE);
        buf_wdata = rx_word;
        sclk      = sclk_q;
    end

    a_r7_ss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ss_n));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ss_n == '1) && !busy);
    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && byte_cnt == '0) |=> done);
    a_r6_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr < MAX_B));
    a_r3_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sclk == cfg_q[CTL_CPOL]));
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[7:6] == 2'b00) && !cfg_q[4]);
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_q));

endmodule

// File: tb/tb_spi_burst_engine.sv
module tb_spi_burst_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_q;
    logic       start = 1'b0;
    logic [7:0] byte_cnt = '0;
    logic [3:0] ss_mask = '0;
    logic       busy, done, buf_we, sclk, mosi, miso;
    logic [7:0] buf_addr, buf_wdata;
    logic [7:0] buf_rdata = '0;
    logic [3:0] ss_n;

    always #2.5 clk = ~clk;

    spi_burst_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .start(start), .byte_cnt(byte_cnt), .ss_mask(ss_mask),
        .busy(busy), .done(done), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    logic [7:0] mem   [0:255];
    logic [7:0] sl_tx [0:255];
    logic [7:0] sl_rx [0:255];

    always @(posedge clk) begin
        buf_rdata <= mem[buf_addr];
        if (buf_we) mem[buf_addr] <= buf_wdata;
    end

    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_cyc = 0;
    int sl_edges = 0, per_bad = 0, ss_bad = 0, we_cnt = 0;
    int exp_half = 2;
    bit tb_cpha = 0, tb_lsb = 0, mon_on = 0;
    logic [3:0] exp_ssn = 4'hF;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Slave model: drives MISO from the edge count, samples MOSI on its sample edges
    logic sel;
    assign sel = ~&ss_n;
    int kk, bb, ii;
    logic [7:0] bt;
    logic miso_r;
    always_comb begin
        kk = sl_edges % 16;
        bb = sl_edges / 16;
        if (tb_cpha) ii = (kk == 0) ? 0 : (kk - 1) / 2;
        else         ii = kk / 2;
        bt = sl_tx[bb];
        miso_r = tb_lsb ? bt[ii] : bt[7 - ii];
    end
    assign miso = sel ? miso_r : 1'b0;

    always @(sclk) begin
        if (sel) begin
            int k, b, i;
            k = sl_edges % 16;
            b = sl_edges / 16;
            if (k != 0 && (cyc - last_cyc) != exp_half) per_bad++;
            last_cyc = cyc;
            if ((k % 2) == int'(tb_cpha)) begin
                i = k / 2;
                if (tb_lsb) sl_rx[b][i] = mosi;
                else        sl_rx[b][7 - i] = mosi;
            end
            sl_edges++;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy && ss_n != exp_ssn) ss_bad++;
            if (!busy && ss_n != 4'hF) ss_bad++;
            if (buf_we) we_cnt++;
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start(input int n, input logic [3:0] m);
        @(negedge clk); start = 1'b1; byte_cnt = 8'(n); ss_mask = m;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk(done, req, 0, 1);
        chk(!busy && ss_n == 4'hF, "R8 release at done", int'(ss_n), 15);
        @(negedge clk);
        chk(!done, "R8 done single cycle", int'(done), 0);
    endtask

    task automatic run_burst(input bit cpha, input bit cpol, input bit lsb,
                             input logic [1:0] dv, input int n, input logic [3:0] m,
                             input int seed);
        int eff, bad_rx, bad_tx;
        logic [7:0] wv, ev;
        eff = (n > 200) ? 200 : n;
        for (int k = 0; k < 256; k++) begin
            mem[k]   = 8'(k * 37 + seed);
            sl_tx[k] = 8'(~(k * 11 + seed * 3));
            sl_rx[k] = 8'h00;
        end
        tb_cpha = cpha; tb_lsb = lsb;
        exp_half = (dv == 0) ? 2 : (dv == 1) ? 8 : (dv == 2) ? 32 : 64;
        // R1: reserved bits are written as ones and must read back as zero
        wv = {2'b11, lsb, 1'b1, cpol, cpha, dv};
        ev = {2'b00, lsb, 1'b0, cpol, cpha, dv};
        write_cfg(wv);
        @(negedge clk);
        chk(cfg_q == ev, "R1 control fields", int'(cfg_q), int'(ev));
        chk(sclk == cpol, "R3 sclk rests at CPOL", int'(sclk), int'(cpol));
        sl_edges = 0; per_bad = 0; ss_bad = 0; we_cnt = 0;
        exp_ssn = ~m; mon_on = 1;
        pulse_start(n, m);
        chk(busy, "R8 busy after start", int'(busy), 1);
        wait_done("R8 done seen");
        mon_on = 0;
        bad_rx = 0; bad_tx = 0;
        for (int k = 0; k < eff; k++) begin
            if (mem[k] != sl_tx[k]) bad_rx++;
            if (sl_rx[k] != 8'(k * 37 + seed)) bad_tx++;
        end
        chk(bad_rx == 0, "R5 R4 R3 received bytes in place", bad_rx, 0);
        chk(bad_tx == 0, "R5 R4 R3 bytes sent on MOSI", bad_tx, 0);
        chk(sl_edges == eff * 16, "R3 edge count", sl_edges, eff * 16);
        chk(per_bad == 0, "R2 half period", per_bad, 0);
        chk(ss_bad == 0, "R7 chip select", ss_bad, 0);
        chk(we_cnt == eff, "R5 write count", we_cnt, eff);
        chk(sclk == cpol, "R3 sclk rest after burst", int'(sclk), int'(cpol));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) begin mem[k] = '0; sl_tx[k] = '0; sl_rx[k] = '0; end
        repeat (4) @(negedge clk);
        chk(!busy && !done && ss_n == 4'hF && sclk == 1'b0 && cfg_q == 8'h00,
            "R7 R8 reset state", int'({busy, done, ss_n}), 15);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every mode and divider code
        for (int md = 0; md < 8; md++) begin
            for (int d = 0; d < 4; d++) begin
                run_burst(md[0], md[1], md[2], 2'(d), 5 - d,
                          4'(1 << ((md + d) % 4)), md * 4 + d + 1);
            end
        end

        // R6: count above the limit is clamped, index 200 untouched
        run_burst(1'b0, 1'b0, 1'b0, 2'b00, 255, 4'b0100, 77);
        chk(mem[200] == 8'(200 * 37 + 77), "R6 byte past limit untouched",
            int'(mem[200]), int'(8'(200 * 37 + 77)));

        // R10: zero count
        mon_on = 1; we_cnt = 0; ss_bad = 0; exp_ssn = 4'hF;
        @(negedge clk); start = 1'b1; byte_cnt = 8'd0; ss_mask = 4'b0010;
        @(negedge clk); start = 1'b0;
        chk(done && !busy && ss_n == 4'hF, "R10 zero count done", int'(done), 1);
        @(negedge clk);
        chk(!done, "R10 done single cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        mon_on = 0;
        chk(we_cnt == 0 && ss_bad == 0, "R10 no writes or select", we_cnt + ss_bad, 0);

        // R9 / R11: start and control writes during a burst are ignored
        begin
            logic [7:0] cfg_before;
            int bad;
            for (int k = 0; k < 256; k++) begin
                mem[k] = 8'(k * 5 + 3); sl_tx[k] = 8'(k * 9 + 1); sl_rx[k] = '0;
            end
            tb_cpha = 1'b1; tb_lsb = 1'b0; exp_half = 8;
            write_cfg(8'b0000_0101);
            cfg_before = cfg_q;
            sl_edges = 0; per_bad = 0; ss_bad = 0; we_cnt = 0;
            exp_ssn = 4'b0111; mon_on = 1;
            pulse_start(4, 4'b1000);
            repeat (30) @(negedge clk);
            start = 1'b1; byte_cnt = 8'd1; ss_mask = 4'b0001;
            cfg_we = 1'b1; cfg_wdata = 8'b0010_1010;
            @(negedge clk); start = 1'b0; cfg_we = 1'b0;
            chk(cfg_q == cfg_before, "R11 control write while busy", int'(cfg_q), int'(cfg_before));
            wait_done("R9 burst completes");
            repeat (20) @(negedge clk);
            mon_on = 0;
            chk(!busy, "R9 no queued burst", int'(busy), 0);
            chk(we_cnt == 4, "R9 write count", we_cnt, 4);
            chk(ss_bad == 0, "R9 select unchanged", ss_bad, 0);
            bad = 0;
            for (int k = 0; k < 4; k++) if (mem[k] != sl_tx[k]) bad++;
            chk(bad == 0, "R9 data of original burst", bad, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule